// File: doc/BRIEF.md
# Parallel BCD Integer Multiplier

This block multiplies two unsigned seven-digit decimal integers held in binary-coded decimal and returns their exact fourteen-digit BCD product. It is fully pipelined. A fresh operand pair may be presented on every clock cycle, and each product emerges a fixed number of cycles later with its own valid flag. Sign, exponent and rounding are handled elsewhere. The block only delivers the exact integer product that such logic consumes.

The work runs in four phases. First, the doubled, quadrupled and quintupled multiplicand are formed digit-locally. Second, for every multiplier digit at once, a pair of terms is picked from zero, X, 2X, 4X and 5X whose sum equals that digit times X, and both terms are recoded into the 4-2-2-1 decimal digit code. Third, the resulting fourteen operands pass through a tree of bitwise 3:2 compressors. A digit-wise doubling step turns each carry vector back into a 4-2-2-1 operand. Fourth, a two-stage decimal adder with a parallel-prefix carry network produces plain BCD.

Any operand digit with a code above nine marks the pair as malformed. The error is reported together with that pair's result slot.

Top module: `bcdm_mul`

## Requirements
- R1: With valid digits, `out_prod` equals the exact decimal product of `in_a` and `in_b`. Digit i of every bus occupies bits [4i+3:4i], with digit 0 the least significant. The product is coded as fourteen BCD digits.
- R2: The result of a pair sampled at a rising edge with `in_valid` high is presented after the eighth rising edge, counting the sampling edge, with the default parameters.
- R3: Pairs presented on consecutive cycles each yield their own correct product on consecutive cycles, with no stall.
- R4: `out_valid` repeats `in_valid` delayed by exactly the latency of R2, including every gap.
- R5: If any digit of either operand exceeds 9 while `in_valid` is high, the matching result has `out_err` high and `out_prod` all zeros.
- R6: `out_err` is never high while `out_valid` is low, and it is low for results whose operands were well-formed.
- R7: While `rst_n` is low, and after release until the first accepted pair has travelled through, `out_valid` and `out_err` are low.
- R8: Every digit of `out_prod` is at most 9 whenever a result without error is presented.
- R9: Every multiplier digit value 0 to 9, at every multiplier digit position, against every multiplicand digit value, gives the correct partial product contribution.
- R10: The all-nines case 9999999 x 9999999 gives 99999980000001, and a zero operand gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the valid and error pipeline |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | 28 | Multiplicand, seven BCD digits |
| in_b | input | 28 | Multiplier, seven BCD digits |
| out_valid | output | 1 | Result present this cycle |
| out_prod | output | 56 | Product, fourteen BCD digits |
| out_err | output | 1 | Operand pair of this result held a digit above 9 |

## Verification
The hardest situation to reach from the ports is one where every selection path is exercised at every digit position while long decimal carry chains cross the full width of the final adder. The stimulus covers this in several ways. A sweep of all hundred single-digit pairs is placed at rotating positions. This is followed by a long back-to-back stream of pseudo-random operands with scattered gaps, and then by the all-nines pair, whose product ripples carries through almost every digit. Malformed digits are injected in the middle of a busy stream and are followed at once by a good pair, to show that the error does not leak into neighbouring results.

// File: rtl/bcdm_pkg.sv
package bcdm_pkg;

    // Number of 3:2 levels needed to bring n operands down to two.
    function automatic int tree_levels(input int n);
        int c;
        int l;
        c = n;
        l = 0;
        while (c > 2) begin
            c = c - c / 3;
            l = l + 1;
        end
        return l;
    endfunction

    // Operand count present at the input of level lv.
    function automatic int ops_after(input int n, input int lv);
        int c;
        c = n;
        for (int i = 0; i < lv; i++) c = c - c / 3;
        return c;
    endfunction

    // Value of a 4-2-2-1 coded digit.
    function automatic logic [3:0] val4221(input logic [3:0] c);
        return ({3'b0, c[3]} << 2) + ({3'b0, c[2]} << 1) + ({3'b0, c[1]} << 1) + {3'b0, c[0]};
    endfunction

    // BCD digit to 4-2-2-1 code.
    function automatic logic [3:0] to4221(input logic [3:0] d);
        logic [3:0] r;
        case (d)
            4'd0: r = 4'b0000;
            4'd1: r = 4'b0001;
            4'd2: r = 4'b0010;
            4'd3: r = 4'b0011;
            4'd4: r = 4'b1000;
            4'd5: r = 4'b1001;
            4'd6: r = 4'b1010;
            4'd7: r = 4'b1011;
            4'd8: r = 4'b1110;
            4'd9: r = 4'b1111;
            default: r = 4'b0000;
        endcase
        return r;
    endfunction

    // Doubles one 4-2-2-1 digit: recode to 5-2-1-1, shift left one bit.
    // Returns {carry_to_next_digit, new 4-2-2-1 digit}.
    function automatic logic [4:0] twice4221(input logic [3:0] h, input logic cin);
        logic [3:0] v;
        logic       w5;
        logic [3:0] r;
        logic [2:0] e;
        v  = val4221(h);
        w5 = (v >= 4'd5);
        r  = w5 ? v - 4'd5 : v;
        case (r)
            4'd0:    e = 3'b000;
            4'd1:    e = 3'b001;
            4'd2:    e = 3'b100;
            4'd3:    e = 3'b101;
            default: e = 3'b111;
        endcase
        return {w5, e, cin};
    endfunction

    // Doubles one BCD digit; returns {carry_out, digit}.
    function automatic logic [4:0] dbl_bcd(input logic [3:0] d, input logic cin);
        logic [4:0] v;
        logic       hi;
        logic [4:0] r;
        v  = {d, 1'b0};
        hi = (v >= 5'd10);
        r  = hi ? v - 5'd10 : v;
        return {hi, 4'(r + {4'b0, cin})};
    endfunction

endpackage

// File: rtl/bcdm_multiples.sv
module bcdm_multiples
    import bcdm_pkg::*;
#(
    parameter int DIGITS = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            tag_i,
    input  logic [4*DIGITS-1:0]   a_i,
    input  logic [4*DIGITS-1:0]   b_i,
    output logic [4*DIGITS+3:0]   m1_o,
    output logic [4*DIGITS+3:0]   m2_o,
    output logic [4*DIGITS+3:0]   m4_o,
    output logic [4*DIGITS+3:0]   m5_o,
    output logic [4*DIGITS-1:0]   b_o,
    output logic [1:0]            tag_o
);
    localparam int MD = DIGITS + 1;
    localparam int MB = 4 * MD;

    logic [MB-1:0] x1, x2, x4, x5, xs;

    always_comb begin
        logic       c2, c4;
        logic [4:0] t;
        x1 = {4'd0, a_i};
        xs = x1 << 4;
        c2 = 1'b0;
        for (int k = 0; k < MD; k++) begin
            t = dbl_bcd(x1[4*k +: 4], c2);
            x2[4*k +: 4] = t[3:0];
            c2 = t[4];
        end
        c4 = 1'b0;
        for (int k = 0; k < MD; k++) begin
            t = dbl_bcd(x2[4*k +: 4], c4);
            x4[4*k +: 4] = t[3:0];
            c4 = t[4];
        end
        for (int k = 0; k < MD; k++) begin
            x5[4*k +: 4] = (x1[4*k] ? 4'd5 : 4'd0) + (xs[4*k +: 4] >> 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tag_o <= 2'b00;
        else        tag_o <= tag_i;
    end

    always_ff @(posedge clk) begin
        m1_o <= x1;
        m2_o <= x2;
        m4_o <= x4;
        m5_o <= x5;
        b_o  <= b_i;
    end
endmodule

// File: rtl/bcdm_pp_select.sv
module bcdm_pp_select
    import bcdm_pkg::*;
#(
    parameter int DIGITS = 7
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [1:0]                            tag_i,
    input  logic [4*DIGITS+3:0]                   m1_i,
    input  logic [4*DIGITS+3:0]                   m2_i,
    input  logic [4*DIGITS+3:0]                   m4_i,
    input  logic [4*DIGITS+3:0]                   m5_i,
    input  logic [4*DIGITS-1:0]                   b_i,
    output logic [2*DIGITS-1:0][8*DIGITS-1:0]     ops_o,
    output logic [1:0]                            tag_o
);
    localparam int MD  = DIGITS + 1;
    localparam int OPS = 2 * DIGITS;
    localparam int WB  = 8 * DIGITS;

    logic [OPS-1:0][WB-1:0] ops_n;

    always_comb begin
        logic [4*MD-1:0] hi, lo;
        ops_n = '0;
        for (int i = 0; i < DIGITS; i++) begin
            unique case (b_i[4*i +: 4])
                4'd0:    begin hi = '0;   lo = '0;   end
                4'd1:    begin hi = m1_i; lo = '0;   end
                4'd2:    begin hi = m2_i; lo = '0;   end
                4'd3:    begin hi = m2_i; lo = m1_i; end
                4'd4:    begin hi = m4_i; lo = '0;   end
                4'd5:    begin hi = m5_i; lo = '0;   end
                4'd6:    begin hi = m5_i; lo = m1_i; end
                4'd7:    begin hi = m5_i; lo = m2_i; end
                4'd8:    begin hi = m4_i; lo = m4_i; end
                4'd9:    begin hi = m5_i; lo = m4_i; end
                default: begin hi = '0;   lo = '0;   end
            endcase
            for (int k = 0; k < MD; k++) begin
                ops_n[2*i][4*(i+k) +: 4]   = to4221(hi[4*k +: 4]);
                ops_n[2*i+1][4*(i+k) +: 4] = to4221(lo[4*k +: 4]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tag_o <= 2'b00;
        else        tag_o <= tag_i;
    end

    always_ff @(posedge clk) begin
        ops_o <= ops_n;
    end
endmodule

// File: rtl/bcdm_csa_tree.sv
module bcdm_csa_tree
    import bcdm_pkg::*;
#(
    parameter int DIGITS = 7,
    parameter int LPS    = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [1:0]                            tag_i,
    input  logic [2*DIGITS-1:0][8*DIGITS-1:0]     ops_i,
    output logic [8*DIGITS-1:0]                   sum_o,
    output logic [8*DIGITS-1:0]                   car_o,
    output logic [1:0]                            tag_o
);
    localparam int W      = 2 * DIGITS;
    localparam int WB     = 4 * W;
    localparam int OPS    = 2 * DIGITS;
    localparam int LEVELS = tree_levels(OPS);

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int NIN  = ops_after(OPS, l);
        localparam int NTRI = NIN / 3;
        localparam bit REG  = ((l % LPS) == LPS - 1) || (l == LEVELS - 1);

        logic [OPS-1:0][WB-1:0] src, res, nxt;
        logic [1:0]             tsrc, tnxt;

        if (l == 0) begin : g_first
            assign src  = ops_i;
            assign tsrc = tag_i;
        end else begin : g_chain
            assign src  = g_lvl[l-1].nxt;
            assign tsrc = g_lvl[l-1].tnxt;
        end

        always_comb begin
            logic [WB-1:0] s, h, dd;
            logic          cy;
            logic [4:0]    t;
            res = '0;
            s   = '0;
            h   = '0;
            dd  = '0;
            cy  = 1'b0;
            t   = '0;
            for (int j = 0; j < NTRI; j++) begin
                s  = src[3*j] ^ src[3*j+1] ^ src[3*j+2];
                h  = (src[3*j] & src[3*j+1]) | (src[3*j] & src[3*j+2]) | (src[3*j+1] & src[3*j+2]);
                cy = 1'b0;
                for (int k = 0; k < W; k++) begin
                    t = twice4221(h[4*k +: 4], cy);
                    dd[4*k +: 4] = t[3:0];
                    cy = t[4];
                end
                res[2*j]   = s;
                res[2*j+1] = dd;
            end
            for (int m = 3 * NTRI; m < NIN; m++) res[m - NTRI] = src[m];
        end

        if (REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) tnxt <= 2'b00;
                else        tnxt <= tsrc;
            end
            always_ff @(posedge clk) begin
                nxt <= res;
            end
        end else begin : g_pass
            assign nxt  = res;
            assign tnxt = tsrc;
        end
    end

    assign sum_o = g_lvl[LEVELS-1].nxt[0];
    assign car_o = g_lvl[LEVELS-1].nxt[1];
    assign tag_o = g_lvl[LEVELS-1].tnxt;
endmodule

// File: rtl/bcdm_cpa.sv
module bcdm_cpa
    import bcdm_pkg::*;
#(
    parameter int DIGITS = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            tag_i,
    input  logic [8*DIGITS-1:0]   sum_i,
    input  logic [8*DIGITS-1:0]   car_i,
    output logic [8*DIGITS-1:0]   prod_o,
    output logic                  valid_o,
    output logic                  err_o
);
    localparam int W = 2 * DIGITS;

    logic [W-1:0][4:0] dsum_n, dsum_q;
    logic [W-1:0]      cin_n, cin_q;
    logic [1:0]        tag_q;
    logic [8*DIGITS-1:0] prod_n;

    // Stage one: digit sums, generate/propagate, parallel-prefix carries.
    always_comb begin
        logic [W-2:0] gg, pp;
        for (int k = 0; k < W; k++) begin
            dsum_n[k] = {1'b0, val4221(sum_i[4*k +: 4])} + {1'b0, val4221(car_i[4*k +: 4])};
        end
        for (int k = 0; k < W - 1; k++) begin
            gg[k] = (dsum_n[k] >= 5'd10);
            pp[k] = (dsum_n[k] == 5'd9);
        end
        for (int s = 1; s < W - 1; s = s * 2) begin
            for (int i = W - 2; i >= s; i--) begin
                gg[i] = gg[i] | (pp[i] & gg[i-s]);
                pp[i] = pp[i] & pp[i-s];
            end
        end
        cin_n = {gg, 1'b0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tag_q <= 2'b00;
        else        tag_q <= tag_i;
    end

    always_ff @(posedge clk) begin
        dsum_q <= dsum_n;
        cin_q  <= cin_n;
    end

    // Stage two: final decimal digit correction.
    always_comb begin
        logic [4:0] t;
        for (int k = 0; k < W; k++) begin
            t = dsum_q[k] + {4'b0, cin_q[k]};
            prod_n[4*k +: 4] = (t >= 5'd10) ? 4'(t - 5'd10) : 4'(t);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= tag_q[1];
            err_o   <= tag_q[0];
        end
    end

    always_ff @(posedge clk) begin
        prod_o <= tag_q[0] ? '0 : prod_n;
    end
endmodule

// File: rtl/bcdm_mul.sv
module bcdm_mul
    import bcdm_pkg::*;
#(
    parameter int DIGITS = 7,
    parameter int LPS    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [4*DIGITS-1:0]   in_a,
    input  logic [4*DIGITS-1:0]   in_b,
    output logic                  out_valid,
    output logic [8*DIGITS-1:0]   out_prod,
    output logic                  out_err
);
    localparam int NB  = 4 * DIGITS;
    localparam int MB  = NB + 4;
    localparam int OPS = 2 * DIGITS;
    localparam int WB  = 8 * DIGITS;

    logic          bad;
    logic [NB-1:0] a_q, b_q;
    logic [1:0]    tag_q;

    always_comb begin
        bad = 1'b0;
        for (int k = 0; k < DIGITS; k++) begin
            if (in_a[4*k +: 4] > 4'd9 || in_b[4*k +: 4] > 4'd9) bad = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tag_q <= 2'b00;
        else        tag_q <= {in_valid, in_valid & bad};
    end

    always_ff @(posedge clk) begin
        a_q <= in_a;
        b_q <= in_b;
    end

    logic [MB-1:0]          m1, m2, m4, m5;
    logic [NB-1:0]          b_m;
    logic [1:0]             tag_m, tag_s, tag_t;
    logic [OPS-1:0][WB-1:0] ops;
    logic [WB-1:0]          tsum, tcar;

    bcdm_multiples #(.DIGITS(DIGITS)) u_mult (
        .clk(clk), .rst_n(rst_n), .tag_i(tag_q), .a_i(a_q), .b_i(b_q),
        .m1_o(m1), .m2_o(m2), .m4_o(m4), .m5_o(m5), .b_o(b_m), .tag_o(tag_m)
    );

    bcdm_pp_select #(.DIGITS(DIGITS)) u_sel (
        .clk(clk), .rst_n(rst_n), .tag_i(tag_m),
        .m1_i(m1), .m2_i(m2), .m4_i(m4), .m5_i(m5), .b_i(b_m),
        .ops_o(ops), .tag_o(tag_s)
    );

    bcdm_csa_tree #(.DIGITS(DIGITS), .LPS(LPS)) u_tree (
        .clk(clk), .rst_n(rst_n), .tag_i(tag_s), .ops_i(ops),
        .sum_o(tsum), .car_o(tcar), .tag_o(tag_t)
    );

    bcdm_cpa #(.DIGITS(DIGITS)) u_cpa (
        .clk(clk), .rst_n(rst_n), .tag_i(tag_t), .sum_i(tsum), .car_i(tcar),
        .prod_o(out_prod), .valid_o(out_valid), .err_o(out_err)
    );
endmodule

// File: rtl/bcdm_mul_chk.sv
module bcdm_mul_chk
    import bcdm_pkg::*;
#(
    parameter int DIGITS = 7,
    parameter int LPS    = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [4*DIGITS-1:0]   in_a,
    input logic [4*DIGITS-1:0]   in_b,
    input logic                  out_valid,
    input logic [8*DIGITS-1:0]   out_prod,
    input logic                  out_err
);
    localparam int LEVELS = tree_levels(2 * DIGITS);
    localparam int LAT    = 5 + (LEVELS + LPS - 1) / LPS;

    logic [LAT-1:0] hv, he;
    logic           in_bad, digits_ok;

    always_comb begin
        in_bad = 1'b0;
        for (int k = 0; k < DIGITS; k++) begin
            if (in_a[4*k +: 4] > 4'd9 || in_b[4*k +: 4] > 4'd9) in_bad = 1'b1;
        end
        digits_ok = 1'b1;
        for (int k = 0; k < 2 * DIGITS; k++) begin
            if (out_prod[4*k +: 4] > 4'd9) digits_ok = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hv <= '0;
            he <= '0;
        end else begin
            hv <= {hv[LAT-2:0], in_valid};
            he <= {he[LAT-2:0], in_valid & in_bad};
        end
    end

    a_r4_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == hv[LAT-1]);

    a_r5_err_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_err == he[LAT-1]);

    a_r5_err_zero_prod: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_prod == '0));

    a_r6_err_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_valid);

    a_r8_digits_decimal: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> digits_ok);
endmodule

bind bcdm_mul bcdm_mul_chk #(.DIGITS(DIGITS), .LPS(LPS)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_prod(out_prod), .out_err(out_err)
);

// File: tb/bcdm_mul_bench.sv
`timescale 1ns/1ps
module bcdm_mul_bench;
    localparam int LAT   = 8;
    localparam int LAST  = 2116;
    localparam int TOTAL = LAST + LAT + 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [27:0] in_a, in_b;
    logic        out_valid;
    logic [55:0] out_prod;
    logic        out_err;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    bcdm_mul u_bcdm_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_prod(out_prod), .out_err(out_err)
    );

    function automatic logic [31:0] mix(input int k);
        logic [31:0] x;
        x = 32'(k) * 32'h9E3779B1;
        x = x ^ (x >> 15);
        x = x * 32'h85EBCA77;
        x = x ^ (x >> 13);
        return x;
    endfunction

    // {valid, a, b} for stimulus index k
    function automatic logic [56:0] stim(input int k);
        logic [27:0] a, b;
        logic        v;
        a = '0; b = '0; v = 1'b1;
        if (k < 100) begin
            a[4*(k%7) +: 4]     = 4'(k / 10);
            b[4*((k/7)%7) +: 4] = 4'(k % 10);
        end else if (k < 110) begin
            v = 1'b0;
            a = 28'(mix(k));
            b = 28'(mix(k + 7));
        end else if (k < 2110) begin
            for (int j = 0; j < 7; j++) begin
                a[4*j +: 4] = 4'(mix(k*16 + j) % 10);
                b[4*j +: 4] = 4'(mix(k*16 + 8 + j) % 10);
            end
            v = (mix(k*16 + 15) & 32'd7) != 0;
        end else if (k == 2110) begin
            a = 28'h9999999; b = 28'h9999999;
        end else if (k == 2111) begin
            a = 28'h0000000; b = 28'h9999999;
        end else if (k == 2112) begin
            a = 28'h123A567; b = 28'h0000001;
        end else if (k == 2113) begin
            a = 28'h0000001; b = 28'hF000000;
        end else if (k == 2114) begin
            a = 28'h9999999; b = 28'h9999999;
        end else if (k == 2115) begin
            a = 28'h1111111; b = 28'h0000009;
        end else begin
            v = 1'b0;
        end
        return {v, a, b};
    endfunction

    function automatic longint bcd2int(input logic [27:0] x);
        longint r;
        r = 0;
        for (int j = 6; j >= 0; j--) r = r * 10 + longint'(x[4*j +: 4]);
        return r;
    endfunction

    function automatic logic [55:0] int2bcd(input longint x);
        logic [55:0] r;
        longint      y;
        y = x;
        for (int j = 0; j < 14; j++) begin
            r[4*j +: 4] = 4'(y % 10);
            y = y / 10;
        end
        return r;
    endfunction

    function automatic bit has_bad(input logic [27:0] x);
        for (int j = 0; j < 7; j++) if (x[4*j +: 4] > 4'd9) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_slot(input int k);
        logic [56:0] s;
        logic [27:0] a, b;
        logic        v, e;
        logic [55:0] p;
        string       req;
        s = stim(k);
        v = s[56]; a = s[55:28]; b = s[27:0];
        e = has_bad(a) || has_bad(b);
        p = e ? 56'd0 : int2bcd(bcd2int(a) * bcd2int(b));
        chk(out_valid == v, "R4 R2 valid timing", 64'(out_valid), 64'(v));
        if (v) begin
            chk(out_err == e, e ? "R5 error flag" : "R6 no error", 64'(out_err), 64'(e));
            if (k < 100)       req = "R9 digit sweep product";
            else if (k < 2110) req = "R3 R1 streamed product";
            else if (e)        req = "R5 zeroed product";
            else               req = "R10 boundary product";
            chk(out_prod == p, req, 64'(out_prod), 64'(p));
        end else begin
            chk(out_err == 1'b0, "R6 err without valid", 64'(out_err), 64'd0);
        end
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0;
        repeat (3) @(negedge clk);
        // R7: outputs quiet while reset is held
        chk(out_valid == 1'b0 && out_err == 1'b0, "R7 reset state",
            64'({out_valid, out_err}), 64'd0);
        in_valid = 1'b1; in_a = 28'h9999999; in_b = 28'hA000000;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0 && out_err == 1'b0, "R7 inputs ignored in reset",
            64'({out_valid, out_err}), 64'd0);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < TOTAL; cyc++) begin
            if (cyc >= LAT) check_slot(cyc - LAT);
            else chk(out_valid == 1'b0 && out_err == 1'b0, "R7 idle after reset",
                     64'({out_valid, out_err}), 64'd0);
            {in_valid, in_a, in_b} = stim(cyc);
            @(negedge clk);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule